// File: doc/BRIEF.md
# Bus Arbitration Control and Error Capture Register

This block is the control and status register of a central bus arbitration point. The CPU accesses it at a single I/O location. Writes set whether the processor may keep using the bus during arbitration, select a short or an extended minimum arbitration cycle, and can lock the arbiter into the arbitration state. Reads return the processor-cycle enable, two error flags and the arbitration level that won the most recent grant.

The error flags record that a non-maskable interrupt event occurred and whether a bus timeout caused it. A read clears both flags. While the NMI flag is set, or once the lock has been written, the arbitration-state output is held active, and no bus master can be granted. The lock is released only by system reset. The minimum arbitration cycle goes out as a clock-cycle count that is derived from the clock frequency and the two nanosecond targets.

Top module: `arb_ctrl_reg`

## Requirements
- R1: After reset, the read value is 0x80, `arbState` is 0, `cpuCycleAllowed` is 1 and `minArbCycles` equals the short count (15 at 50 MHz).
- R2: The read layout is: bit 7 processor-cycle enable, bit 6 NMI flag, bit 5 timeout flag, bit 4 always 0, bits 3..0 last granted level. `rdData` is combinational from the stored state.
- R3: On a clock edge with `grantValid` high, `grantLevel` is stored. Without `grantValid`, the stored level does not change.
- R4: A pulse on `nmiEvent` or `busTimeout` sets the NMI flag and drives `arbState` high from the next cycle. The timeout flag takes the value of `busTimeout` in that event, so an NMI without a timeout leaves it at 0.
- R5: A read (`cpuRd`) clears both flags at the clock edge that ends it. An event in the same cycle as the read takes priority, and the flags are left set.
- R6: A write with bit 6 = 1 holds `arbState` at 1. Later writes, reads and flag clears do not release it. Only reset releases it.
- R7: A write loads bit 7 as the processor-cycle enable. `cpuCycleAllowed` is 1 when `arbState` is 0, and otherwise equals the enable.
- R8: A write loads bit 5 as the extended-cycle mode. `minArbCycles` is the short count (15) when the mode is 0 and the long count (30) when it is 1.
- R9: Written bits 4..0 are ignored and do not change the read value or `minArbCycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| cpuWr | input | 1 | CPU write strobe, one cycle |
| cpuRd | input | 1 | CPU read strobe, one cycle |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | CPU read data |
| nmiEvent | input | 1 | NMI event pulse |
| busTimeout | input | 1 | Bus-timeout event pulse |
| grantValid | input | 1 | A grant completed this cycle |
| grantLevel | input | 4 | Arbitration level of that grant |
| arbState | output | 1 | Arbiter forced into arbitration state |
| cpuCycleAllowed | output | 1 | Processor may use the bus |
| minArbCycles | output | CYC_W | Minimum arbitration cycle in clocks |

## Verification
The hardest cases to reach from the ports are an event that arrives in the same cycle as the clearing read, and a lock that must survive later writes, reads and flag clears. The bench raises `cpuRd` and `nmiEvent` on the same negative edge, so both are seen at one rising edge, and then reads again to confirm that the flag stayed set. The lock test runs last. It writes the lock, then writes zero to bit 6, reads, and raises and clears an NMI. It then pulses reset to show that reset is the only release.

// File: rtl/arb_ctrl_pkg.sv
package arb_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic setMask;
    logic clearFlags;
    logic raiseNmi;
    logic timeoutCause;
    logic captureLevel;
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl_fsm.sv
module arb_ctrl_fsm
  import arb_ctrl_pkg::*;
(
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nmiEvent,
  input  logic              busTimeout,
  input  logic              grantValid,
  output arbStrobe_t        strobe
);
  always_comb begin
    strobe              = '0;
    strobe.loadCfg      = cpuWr;
    strobe.setMask      = cpuWr && wrData[6];
    strobe.raiseNmi     = nmiEvent || busTimeout;
    strobe.timeoutCause = busTimeout;
    strobe.clearFlags   = cpuRd;
    strobe.captureLevel = grantValid;
  end
endmodule

// File: rtl/arb_ctrl_dp.sv
module arb_ctrl_dp
  import arb_ctrl_pkg::*;
#(
  parameter int CYC_W     = 6,
  parameter int SHORT_CYC = 15,
  parameter int LONG_CYC  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LVL_W-1:0]  grantLevel,
  output logic [DATA_W-1:0] rdData,
  output logic              arbState,
  output logic              cpuCycleAllowed,
  output logic [CYC_W-1:0]  minArbCycles
);
  logic             epcReg;
  logic             extReg;
  logic             maskReg;
  logic             nmiFlag;
  logic             btoFlag;
  logic [LVL_W-1:0] lastLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcReg    <= 1'b1;
      extReg    <= 1'b0;
      maskReg   <= 1'b0;
      nmiFlag   <= 1'b0;
      btoFlag   <= 1'b0;
      lastLevel <= '0;
    end else begin
      if (strobe.loadCfg) begin
        epcReg <= wrData[7];
        extReg <= wrData[5];
      end
      if (strobe.setMask) maskReg <= 1'b1;
      if (strobe.captureLevel) lastLevel <= grantLevel;
      if (strobe.raiseNmi) begin
        nmiFlag <= 1'b1;
        btoFlag <= strobe.timeoutCause;
      end else if (strobe.clearFlags) begin
        nmiFlag <= 1'b0;
        btoFlag <= 1'b0;
      end
    end
  end

  assign rdData          = {epcReg, nmiFlag, btoFlag, 1'b0, lastLevel};
  assign arbState        = maskReg || nmiFlag;
  assign cpuCycleAllowed = !arbState || epcReg;
  assign minArbCycles    = extReg ? CYC_W'(LONG_CYC) : CYC_W'(SHORT_CYC);
endmodule

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
  import arb_ctrl_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int SHORT_NS = 300,
  parameter int LONG_NS  = 600,
  parameter int CYC_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              nmiEvent,
  input  logic              busTimeout,
  input  logic              grantValid,
  input  logic [3:0]        grantLevel,
  output logic              arbState,
  output logic              cpuCycleAllowed,
  output logic [CYC_W-1:0]  minArbCycles
);
  localparam int SHORT_CYC = (SHORT_NS * CLK_MHZ + 999) / 1000;
  localparam int LONG_CYC  = (LONG_NS * CLK_MHZ + 999) / 1000;

  arbStrobe_t strobe;

  arb_ctrl_fsm uCtl (
    .cpuWr(cpuWr), .cpuRd(cpuRd), .wrData(wrData),
    .nmiEvent(nmiEvent), .busTimeout(busTimeout),
    .grantValid(grantValid), .strobe(strobe)
  );

  arb_ctrl_dp #(.CYC_W(CYC_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .grantLevel(grantLevel), .rdData(rdData), .arbState(arbState),
    .cpuCycleAllowed(cpuCycleAllowed), .minArbCycles(minArbCycles)
  );
endmodule

// File: rtl/arb_ctrl_reg_chk.sv
module arb_ctrl_reg_chk #(
  parameter int CYC_W     = 6,
  parameter int SHORT_CYC = 15,
  parameter int LONG_CYC  = 30
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuWr,
  input logic             cpuRd,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic             nmiEvent,
  input logic             busTimeout,
  input logic             grantValid,
  input logic [3:0]       grantLevel,
  input logic             arbState,
  input logic             cpuCycleAllowed,
  input logic [CYC_W-1:0] minArbCycles
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[4] == 1'b0);

  // R3
  level_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> rdData[3:0] == $past(grantLevel));

  // R4
  nmi_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiEvent || busTimeout) |=> (arbState && rdData[6] && rdData[5] == $past(busTimeout)));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !nmiEvent && !busTimeout) |=> (rdData[6:5] == 2'b00));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arbState && !rdData[6]) |=> arbState);

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && wrData[6]) |=> arbState);

  // R7
  cpu_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuCycleAllowed == (!arbState || rdData[7]));

  // R8
  min_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr |=> minArbCycles == ($past(wrData[5]) ? CYC_W'(LONG_CYC) : CYC_W'(SHORT_CYC)));
endmodule

bind arb_ctrl_reg arb_ctrl_reg_chk #(.CYC_W(CYC_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) uChk (
  .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .wrData(wrData),
  .rdData(rdData), .nmiEvent(nmiEvent), .busTimeout(busTimeout),
  .grantValid(grantValid), .grantLevel(grantLevel), .arbState(arbState),
  .cpuCycleAllowed(cpuCycleAllowed), .minArbCycles(minArbCycles)
);

// File: tb/arb_ctrl_reg_test.sv
`timescale 1ns/1ps
module arb_ctrl_reg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       nmiEvent = 1'b0, busTimeout = 1'b0, grantValid = 1'b0;
  logic [3:0] grantLevel = '0;
  logic       arbState, cpuCycleAllowed;
  logic [5:0] minArbCycles;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  arb_ctrl_reg uut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .wrData(wrData),
    .rdData(rdData), .nmiEvent(nmiEvent), .busTimeout(busTimeout),
    .grantValid(grantValid), .grantLevel(grantLevel), .arbState(arbState),
    .cpuCycleAllowed(cpuCycleAllowed), .minArbCycles(minArbCycles)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); cpuWr = 1'b1; wrData = d;
    @(negedge clk); cpuWr = 1'b0; wrData = '0;
  endtask

  task automatic doRead(output logic [7:0] v);
    @(negedge clk); cpuRd = 1'b1; #1 v = rdData;
    @(negedge clk); cpuRd = 1'b0;
  endtask

  task automatic pulse(input logic nmi, input logic tmo);
    @(negedge clk); nmiEvent = nmi; busTimeout = tmo;
    @(negedge clk); nmiEvent = 1'b0; busTimeout = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 arbState", int'(arbState), 0);
    check("R1 cpuCycleAllowed", int'(cpuCycleAllowed), 1);
    check("R1 minArbCycles", int'(minArbCycles), 15);
    doRead(v);
    check("R1 R2 read value", int'(v), 'h80);
  endtask

  task automatic testLevel();
    logic [7:0] v;
    @(negedge clk); grantValid = 1'b1; grantLevel = 4'hA;
    @(negedge clk); grantValid = 1'b0; grantLevel = 4'h3;
    @(negedge clk);
    doRead(v);
    check("R3 level stored", int'(v), 'h8A);
    @(negedge clk); grantValid = 1'b1; grantLevel = 4'h5;
    @(negedge clk); grantValid = 1'b0; grantLevel = 4'hF;
    doRead(v);
    check("R3 level updated", int'(v), 'h85);
  endtask

  task automatic testNmi();
    logic [7:0] v;
    pulse(1'b1, 1'b0);
    check("R4 arbState after nmi", int'(arbState), 1);
    doRead(v);
    check("R2 R4 nmi readback", int'(v), 'hC5);
    check("R5 arbState released", int'(arbState), 0);
    doRead(v);
    check("R5 flags cleared", int'(v), 'h85);
    pulse(1'b0, 1'b1);
    doRead(v);
    check("R4 timeout readback", int'(v), 'hE5);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    doRead(v);
    check("R4 later nmi clears timeout cause", int'(v), 'hC5);
    // read and event in the same cycle
    @(negedge clk); cpuRd = 1'b1; nmiEvent = 1'b1; #1 v = rdData;
    @(negedge clk); cpuRd = 1'b0; nmiEvent = 1'b0;
    check("R5 read value before event", int'(v), 'h85);
    doRead(v);
    check("R5 event wins over clear", int'(v), 'hC5);
  endtask

  task automatic testEpc();
    logic [7:0] v;
    doWrite(8'h00);
    doRead(v);
    check("R7 enable cleared", int'(v), 'h05);
    check("R7 allowed while idle", int'(cpuCycleAllowed), 1);
    pulse(1'b1, 1'b0);
    check("R7 blocked in arbitration", int'(cpuCycleAllowed), 0);
    doRead(v);
    doWrite(8'h80);
    pulse(1'b1, 1'b0);
    check("R7 allowed with enable", int'(cpuCycleAllowed), 1);
    doRead(v);
  endtask

  task automatic testExt();
    logic [7:0] v;
    doWrite(8'hA0);
    check("R8 long count", int'(minArbCycles), 30);
    doWrite(8'h80);
    check("R8 short count", int'(minArbCycles), 15);
    doWrite(8'h9F);
    doRead(v);
    check("R9 reserved bits ignored", int'(v), 'h85);
    check("R9 count unchanged", int'(minArbCycles), 15);
    check("R9 arbState unchanged", int'(arbState), 0);
  endtask

  task automatic testMask();
    logic [7:0] v;
    doWrite(8'hC0);
    check("R6 lock forces arbState", int'(arbState), 1);
    doWrite(8'h80);
    check("R6 lock survives write", int'(arbState), 1);
    pulse(1'b1, 1'b0);
    doRead(v);
    check("R6 lock not readable", int'(v), 'hC5);
    doRead(v);
    check("R6 lock survives read", int'(arbState), 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R6 reset releases lock", int'(arbState), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLevel();
    testNmi();
    testEpc();
    testExt();
    testMask();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule